// File: doc/BRIEF.md
# Cascadable Dual-Edge Column Word Loader

This block loads one row of column data into a bank of word registers. A select token comes in from a neighbouring device. It arrives together with a rising edge of the shift clock, and that edge writes the word on the shared bus into the first slot of the fill order. After that, every shift-clock edge writes the next bus word into the next slot, whether the edge rises or falls. Two slots therefore fill per shift-clock period. When the last slot in the order has been written, the block passes the token to the next device in the chain. It holds the token there for one shift-clock half period and then returns to idle.

A direction input sets the fill order and swaps the roles of the two token sides. In ascending mode the token enters on side A, the slots fill from lowest to highest, and the token leaves on side B. In descending mode the token enters on side B, the slots fill from highest to lowest, and the token leaves on side A. Devices can therefore be chained along either edge of a panel. The shift clock and the token inputs are asynchronous to the system clock. Two-stage synchronizers sample them, and edge detection turns the synchronized shift clock into single-cycle rise and fall strobes. The data bus passes through a delay of the same depth, so each strobe sees the word that was on the bus when its edge occurred.

Top module: `col_loader`

## Requirements
- R1: While rst_ni is low, and until the first write after its release, every slot reads zero, busy_o is low and both token outputs are low.
- R2: A load starts only when the block is idle, the entry token input is high and the shift clock rises. That rising edge writes the bus word into the first slot of the order and raises busy_o. An entry token that is high only across a falling edge does not start a load.
- R3: Once a load has started, every following shift-clock edge, rising or falling, writes the bus word into the next slot. 32 edges therefore fill all slots.
- R4: With dir_i high, the entry is tok_a_i. The k-th word of a load goes to slot k (slot k is slots_o[7k+6:7k], k = 0..31), and the exit is tok_b_o.
- R5: With dir_i low, the entry is tok_b_i. The k-th word of a load goes to slot 31-k, and the exit is tok_a_o.
- R6: After the last slot is written, only the exit token output goes high, for exactly one shift-clock half period (8 system cycles when the half period is 8 cycles). It falls on the next shift-clock edge, at which point busy_o falls. The exit output is never high while busy_o is low.
- R7: Token inputs that arrive while a load or exit phase is in progress are ignored. A token on the side that is not the entry for the current dir_i is also ignored.
- R8: Slot contents change only on a write. Shift-clock edges while idle, with no valid entry token, leave every slot and busy_o unchanged.
- R9: dir_i is captured when a load starts. Changing dir_i during the load changes neither the fill order nor the exit side of that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the shift clock and token inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 7 | Shared data bus word |
| shclk_i | input | 1 | Shift clock; both edges write a slot during a load |
| dir_i | input | 1 | Fill direction: 1 ascending (enter A, exit B), 0 descending (enter B, exit A) |
| tok_a_i | input | 1 | Token input on side A |
| tok_a_o | output | 1 | Token output on side A |
| tok_b_i | input | 1 | Token input on side B |
| tok_b_o | output | 1 | Token output on side B |
| slots_o | output | 224 | 32 latched words, slot k at bits [7k+6:7k] |
| busy_o | output | 1 | High from the first write until the exit token is released |

## Verification
The assertions check on every cycle that at most one token output is high and that a token output is high only while busy_o is high. They also check that slot contents and busy_o change only on a shift-clock strobe, and that busy_o rises only on a rising strobe. Only the bench scenarios can show which slot each bus word lands in under each direction, the exact width of the exit pulse, and that a dir_i change or a second token in mid-load is ignored. The bench compares every slot against a model built from the words it drove.

// File: rtl/colload_pkg.sv
package colload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EXIT = 2'd2
  } ld_state_e;
endpackage

// File: rtl/col_sync.sv
// Multi-stage register chain: synchronizer for async inputs, aligner for data.
module col_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/col_edge_det.sv
module col_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_i;
  end

  assign rise_o = s_i & ~prev_q;
  assign fall_o = ~s_i & prev_q;
endmodule

// File: rtl/col_seq.sv
// Token capture, slot ordering and cascade hand-off.
module col_seq
  import colload_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             dir_i,
  input  logic             tok_a_i,
  input  logic             tok_b_i,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             tok_a_o,
  output logic             tok_b_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NUM_SLOTS - 1);

  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ord, pos;
  logic             dir_q, dir_d, dir_eff;
  logic             exit_q, exit_d;
  logic             entry_tok, start, step, last, any_edge;

  always_comb begin
    any_edge  = rise_i | fall_i;
    entry_tok = dir_i ? tok_a_i : tok_b_i;
    start     = (state_q == ST_IDLE) && rise_i && entry_tok;
    step      = (state_q == ST_LOAD) && any_edge;
    we_o      = start | step;
    ord       = start ? '0 : cnt_q;
    dir_eff   = start ? dir_i : dir_q;
    pos       = dir_eff ? ord : (LAST_POS - ord);
    idx_o     = pos[IDX_W-1:0];
    last      = (ord == LAST_POS);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    exit_d  = exit_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        dir_d = dir_i;
        if (last) begin
          state_d = ST_EXIT;
          exit_d  = 1'b1;
        end else begin
          state_d = ST_LOAD;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_LOAD: if (step) begin
        if (last) begin
          state_d = ST_EXIT;
          exit_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_EXIT: if (any_edge) begin
        state_d = ST_IDLE;
        exit_d  = 1'b0;
      end
      default: begin
        state_d = ST_IDLE;
        exit_d  = 1'b0;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
      exit_q  <= exit_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign tok_b_o = exit_q & dir_q;
  assign tok_a_o = exit_q & ~dir_q;
endmodule

// File: rtl/col_slot_bank.sv
module col_slot_bank #(
  parameter int DATA_W    = 7,
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           d_i,
  output logic [NUM_SLOTS*DATA_W-1:0] slots_o
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            slot_q <= '0;
      else if (we_i && (idx_i == IDX_W'(k)))  slot_q <= d_i;
    end
    assign slots_o[k*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/col_loader.sv
module col_loader #(
  parameter int DATA_W      = 7,
  parameter int NUM_SLOTS   = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_SLOTS),
  localparam int BANK_W     = NUM_SLOTS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shclk_i,
  input  logic              dir_i,
  input  logic              tok_a_i,
  output logic              tok_a_o,
  input  logic              tok_b_i,
  output logic              tok_b_o,
  output logic [BANK_W-1:0] slots_o,
  output logic              busy_o
);
  logic [2:0]        ctl_s;
  logic [DATA_W-1:0] data_s;
  logic              rise_stb, fall_stb;
  logic              we;
  logic [IDX_W-1:0]  idx;

  col_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tok_b_i, tok_a_i, shclk_i}),
    .q_o   (ctl_s)
  );

  // Same depth as the control path so each strobe sees its own bus word.
  col_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_data_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .q_o   (data_s)
  );

  col_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (ctl_s[0]),
    .rise_o(rise_stb),
    .fall_o(fall_stb)
  );

  col_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise_stb),
    .fall_i (fall_stb),
    .dir_i  (dir_i),
    .tok_a_i(ctl_s[1]),
    .tok_b_i(ctl_s[2]),
    .we_o   (we),
    .idx_o  (idx),
    .busy_o (busy_o),
    .tok_a_o(tok_a_o),
    .tok_b_o(tok_b_o)
  );

  col_slot_bank #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .idx_i  (idx),
    .d_i    (data_s),
    .slots_o(slots_o)
  );
endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int BANK_W = 224
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              tok_a_o,
  input logic              tok_b_o,
  input logic [BANK_W-1:0] slots_o,
  input logic              rise_stb,
  input logic              fall_stb
);
  a_r6_single_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tok_a_o, tok_b_o}));

  a_r6_exit_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_a_o | tok_b_o) |-> busy_o);

  a_r6_release_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tok_a_o | tok_b_o) |-> !busy_o);

  a_r8_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_stb | fall_stb) |=> $stable(slots_o));

  a_r3_busy_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_stb | fall_stb) |=> $stable(busy_o));

  a_r2_start_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(rise_stb));
endmodule

bind col_loader col_loader_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .tok_a_o (tok_a_o),
  .tok_b_o (tok_b_o),
  .slots_o (slots_o),
  .rise_stb(rise_stb),
  .fall_stb(fall_stb)
);

// File: tb/tb_col_loader.sv
`timescale 1ns/1ps
module tb_col_loader;
  localparam int DW = 7;
  localparam int NS = 32;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic shclk_i = 1'b0, dir_i = 1'b1, tok_a_i = 1'b0, tok_b_i = 1'b0;
  logic tok_a_o, tok_b_o, busy_o;
  logic [NS*DW-1:0] slots_o;

  int checks = 0, errors = 0;
  int pulse_cnt = 0;
  logic [DW-1:0] exp_slot [NS];

  always #2 clk = ~clk;

  col_loader dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .shclk_i(shclk_i),
    .dir_i(dir_i), .tok_a_i(tok_a_i), .tok_a_o(tok_a_o),
    .tok_b_i(tok_b_i), .tok_b_o(tok_b_o), .slots_o(slots_o), .busy_o(busy_o)
  );

  always @(posedge clk) if (tok_a_o | tok_b_o) pulse_cnt <= pulse_cnt + 1;

  function automatic logic [DW-1:0] get_slot(input int k);
    return slots_o[k*DW +: DW];
  endfunction

  function automatic int map_pos(input bit dir, input int k);
    return dir ? k : NS - 1 - k;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NS; k++)
      chk(get_slot(k) == exp_slot[k], req, int'(get_slot(k)), int'(exp_slot[k]));
  endtask

  task automatic edge_with(input logic [DW-1:0] w);
    data_i = w;
    repeat (HALF/2) @(negedge clk);
    shclk_i = ~shclk_i;
    repeat (HALF/2) @(negedge clk);
  endtask

  task automatic ensure_low();
    if (shclk_i) edge_with(DW'($urandom()));
  endtask

  task automatic run_load(input bit dir, input bit mid_tok, input bit flip_dir, input string req);
    logic [DW-1:0] w [NS];
    for (int k = 0; k < NS; k++) w[k] = DW'($urandom());
    ensure_low();
    dir_i = dir;
    if (dir) tok_a_i = 1'b1; else tok_b_i = 1'b1;
    for (int k = 0; k < NS; k++) begin
      if (flip_dir && k == 12) dir_i = ~dir;
      if (mid_tok && k == 10) begin tok_a_i = 1'b1; tok_b_i = 1'b1; end
      if (mid_tok && k == 14) begin tok_a_i = 1'b0; tok_b_i = 1'b0; end
      edge_with(w[k]);
      exp_slot[map_pos(dir, k)] = w[k];
      if (k == 0) begin
        tok_a_i = 1'b0; tok_b_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
      end
      if (k == 16)
        chk((tok_a_o | tok_b_o) == 1'b0, "R3 no exit mid-load", int'({tok_a_o, tok_b_o}), 0);
    end
    pulse_cnt = 0;
    // exit on the far side only
    chk(tok_b_o == dir, {req, " R6 exit side B"}, int'(tok_b_o), int'(dir));
    chk(tok_a_o == !dir, {req, " R6 exit side A"}, int'(tok_a_o), int'(!dir));
    chk(busy_o == 1'b1, "R6 busy during exit", int'(busy_o), 1);
    edge_with(DW'($urandom()));
    chk((tok_a_o | tok_b_o) == 1'b0, "R6 exit released", int'({tok_a_o, tok_b_o}), 0);
    chk(busy_o == 1'b0, "R6 idle after exit", int'(busy_o), 0);
    chk(pulse_cnt == HALF - 1 || pulse_cnt == HALF, "R6 pulse width", pulse_cnt, HALF);
    check_bank(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'hC01D_5EED));
    for (int k = 0; k < NS; k++) exp_slot[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bank("R1 reset slot");
    chk(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
    chk({tok_a_o, tok_b_o} == 2'b00, "R1 tokens reset", int'({tok_a_o, tok_b_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R8 idle edges without token
    for (int i = 0; i < 6; i++) edge_with(DW'($urandom()));
    chk(busy_o == 1'b0, "R8 idle edges busy", int'(busy_o), 0);
    check_bank("R8 idle edges slot");

    // R7 token on the non-entry side
    ensure_low();
    dir_i = 1'b1; tok_b_i = 1'b1;
    edge_with(7'h55);
    edge_with(7'h2A);
    tok_b_i = 1'b0;
    chk(busy_o == 1'b0, "R7 wrong side busy", int'(busy_o), 0);
    check_bank("R7 wrong side slot");

    // R2 token present only across a falling edge
    if (!shclk_i) edge_with(7'h11);
    tok_a_i = 1'b1;
    edge_with(7'h33);
    tok_a_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0, "R2 fall does not start", int'(busy_o), 0);
    check_bank("R2 fall no write");

    run_load(1'b1, 1'b0, 1'b0, "R4 ascending R3");
    run_load(1'b0, 1'b0, 1'b0, "R5 descending");
    run_load(1'b1, 1'b1, 1'b0, "R7 token during load");
    run_load(1'b0, 1'b1, 1'b1, "R9 dir change mid-load");
    run_load(1'b1, 1'b0, 1'b1, "R9 dir change ascending");

    // R8 contents hold after a load
    for (int i = 0; i < 5; i++) edge_with(DW'($urandom()));
    check_bank("R8 hold after load");

    for (int i = 0; i < 3; i++) run_load(1'($urandom()), 1'b0, 1'b0, "R3 random load");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule